// File: doc/BRIEF.md
# Iterative Mantissa Shifter

This block shifts the 36-bit two's-complement mantissa of a floating accumulator, and optionally the mantissa of the low-order result register joined below it, by 0 to 63 bit positions. A 3-bit mode code selects the behaviour. Bit 2 selects the direction (0 left, 1 right). Bit 1 selects the width (0 accumulator only, 1 both registers joined). Bit 0 selects the type (0 rotate, 1 arithmetic). The block is used by the execution stage of a scientific unit. That stage presents both mantissas, both exponents, the mode and the count together with a one-cycle start strobe. It then waits for the done pulse.

The work is done iteratively: up to four bit positions per clock, so the latency follows the count. The exponent fields are never shifted. They sit in output registers that hold the presented exponents while the operation runs, and they read zero once it ends. Rotates lose no bits. Arithmetic shifts keep the sign positions fixed and discard bits that pass the end of the field.

Top module: `mant_shifter`

## Requirements
- R1: The mode code is decoded per bit: bit 2 set means right (clear means left), bit 1 set means double precision (accumulator above low-order register), bit 0 set means arithmetic (clear means rotate); all eight codes 0..7 are legal.
- R2: Single rotate (codes 0 and 4) rotates all 36 accumulator bits by count modulo 36 in the chosen direction, so no bit is lost.
- R3: Double rotate (codes 2 and 6) rotates the 72-bit value {accumulator, low-order} by count modulo 72, with bits crossing between the two registers.
- R4: Single arithmetic (codes 1 and 5) keeps the accumulator sign bit 35 fixed and shifts bits 34..0. A left shift fills with zeros and a right shift fills with the sign. Bits shifted out are lost, so counts of 35 or more leave all zeros (left) or all sign copies (right).
- R5: Double arithmetic (codes 3 and 7) shifts a 70-bit field made of accumulator bits 34..0 above low-order bits 34..0. A left shift fills with zeros and a right shift fills with the accumulator sign. Both sign bits (bit 35 of each register) keep their input values.
- R6: In single-precision modes the low-order mantissa output equals the low-order mantissa input.
- R7: Both exponent outputs read zero in the cycle where done is high. From the start edge until completion they hold the exponent inputs presented with start.
- R8: Done rises 1 + ceil(count/4) clock edges after the edge that accepts start. A count of zero gives done on the second edge, with unchanged mantissas and cleared exponents.
- R9: Done is a one-cycle pulse. The mantissa outputs change only on the edge that raises done and hold their value between operations.
- R10: A start strobe while an operation is in progress is ignored and does not alter the running result.
- R11: After synchronous reset, done is low and all mantissa and exponent outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; accepted only when idle |
| mode | input | 3 | Shift mode code (right, double, arithmetic) |
| count | input | 6 | Shift distance 0..63 |
| acc_mant_i | input | 36 | Accumulator mantissa operand |
| lor_mant_i | input | 36 | Low-order register mantissa operand |
| acc_exp_i | input | 12 | Accumulator exponent presented with start |
| lor_exp_i | input | 12 | Low-order exponent presented with start |
| acc_mant_o | output | 36 | Shifted accumulator mantissa |
| lor_mant_o | output | 36 | Shifted (or unchanged) low-order mantissa |
| acc_exp_o | output | 12 | Accumulator exponent; zero at completion |
| lor_exp_o | output | 12 | Low-order exponent; zero at completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start strobe that arrives while an operation is still running. The bench reaches it by launching a long shift with count 61. It then pulses start again, with a different mode, count and operands, one cycle later. The result that follows must match only the first request. The double-arithmetic right shift of 36 is also targeted: there the accumulator sign has to cross the protected low-order sign bit into the lower field.

// File: rtl/msh_pkg.sv
package msh_pkg;

  // Decoded shift mode; the packed order matches the 3-bit code
  typedef struct packed {
    logic right;  // code bit 2
    logic dbl;    // code bit 1
    logic arith;  // code bit 0
  } msh_mode_t;

  typedef enum logic [2:0] {
    MSH_LROT_S = 3'd0,
    MSH_LARI_S = 3'd1,
    MSH_LROT_D = 3'd2,
    MSH_LARI_D = 3'd3,
    MSH_RROT_S = 3'd4,
    MSH_RARI_S = 3'd5,
    MSH_RROT_D = 3'd6,
    MSH_RARI_D = 3'd7
  } msh_code_e;

endpackage

// File: rtl/msh_bit_stage.sv
module msh_bit_stage
  import msh_pkg::*;
#(
  parameter int MANT_W = 36
) (
  input  logic              en,
  input  msh_mode_t         md,
  input  logic [MANT_W-1:0] acc_in,
  input  logic [MANT_W-1:0] lor_in,
  output logic [MANT_W-1:0] acc_out,
  output logic [MANT_W-1:0] lor_out
);

  localparam int TOP = MANT_W - 1;

  always_comb begin
    acc_out = acc_in;
    lor_out = lor_in;
    if (en) begin
      case ({md.right, md.dbl, md.arith})
        3'b000: acc_out = {acc_in[TOP-1:0], acc_in[TOP]};
        3'b001: acc_out = {acc_in[TOP], acc_in[TOP-2:0], 1'b0};
        3'b010: begin
          acc_out = {acc_in[TOP-1:0], lor_in[TOP]};
          lor_out = {lor_in[TOP-1:0], acc_in[TOP]};
        end
        3'b011: begin
          acc_out = {acc_in[TOP], acc_in[TOP-2:0], lor_in[TOP-1]};
          lor_out = {lor_in[TOP], lor_in[TOP-2:0], 1'b0};
        end
        3'b100: acc_out = {acc_in[0], acc_in[TOP:1]};
        3'b101: acc_out = {acc_in[TOP], acc_in[TOP], acc_in[TOP-1:1]};
        3'b110: begin
          acc_out = {lor_in[0], acc_in[TOP:1]};
          lor_out = {acc_in[0], lor_in[TOP:1]};
        end
        default: begin
          acc_out = {acc_in[TOP], acc_in[TOP], acc_in[TOP-1:1]};
          lor_out = {lor_in[TOP], acc_in[0], lor_in[TOP-1:1]};
        end
      endcase
    end
  end

endmodule

// File: rtl/msh_step.sv
module msh_step
  import msh_pkg::*;
#(
  parameter int MANT_W = 36,
  parameter int STEP   = 4,
  parameter int AMT_W  = $clog2(STEP + 1)
) (
  input  msh_mode_t         md,
  input  logic [AMT_W-1:0]  amt,
  input  logic [MANT_W-1:0] acc_in,
  input  logic [MANT_W-1:0] lor_in,
  output logic [MANT_W-1:0] acc_out,
  output logic [MANT_W-1:0] lor_out
);

  logic [MANT_W-1:0] acc_chain [STEP+1];
  logic [MANT_W-1:0] lor_chain [STEP+1];

  assign acc_chain[0] = acc_in;
  assign lor_chain[0] = lor_in;

  for (genvar g = 0; g < STEP; g++) begin : g_stage
    logic stage_en;
    assign stage_en = (amt > AMT_W'(g));
    msh_bit_stage #(.MANT_W(MANT_W)) u_bit (
      .en     (stage_en),
      .md     (md),
      .acc_in (acc_chain[g]),
      .lor_in (lor_chain[g]),
      .acc_out(acc_chain[g+1]),
      .lor_out(lor_chain[g+1])
    );
  end

  assign acc_out = acc_chain[STEP];
  assign lor_out = lor_chain[STEP];

endmodule

// File: rtl/msh_seq.sv
module msh_seq #(
  parameter int CNT_W = 6,
  parameter int STEP  = 4,
  parameter int AMT_W = $clog2(STEP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             accept,
  output logic             finish,
  output logic [AMT_W-1:0] amt
);

  logic [CNT_W-1:0] remain;

  assign accept = start && !busy;
  assign finish = busy && (remain == '0);
  assign amt    = (remain >= CNT_W'(STEP)) ? AMT_W'(STEP) : AMT_W'(remain);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      remain <= count;
    end else if (finish) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - CNT_W'(amt);
    end
  end

endmodule

// File: rtl/mant_shifter.sv
module mant_shifter
  import msh_pkg::*;
#(
  parameter int MANT_W = 36,
  parameter int EXP_W  = 12,
  parameter int CNT_W  = 6,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [CNT_W-1:0]  count,
  input  logic [MANT_W-1:0] acc_mant_i,
  input  logic [MANT_W-1:0] lor_mant_i,
  input  logic [EXP_W-1:0]  acc_exp_i,
  input  logic [EXP_W-1:0]  lor_exp_i,
  output logic [MANT_W-1:0] acc_mant_o,
  output logic [MANT_W-1:0] lor_mant_o,
  output logic [EXP_W-1:0]  acc_exp_o,
  output logic [EXP_W-1:0]  lor_exp_o,
  output logic              done
);

  localparam int AMT_W = $clog2(STEP + 1);

  msh_mode_t         md_q;
  logic [MANT_W-1:0] acc_w, lor_w, acc_nx, lor_nx;
  logic              busy, accept, finish;
  logic [AMT_W-1:0]  amt;

  msh_seq #(.CNT_W(CNT_W), .STEP(STEP), .AMT_W(AMT_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .count (count),
    .busy  (busy),
    .accept(accept),
    .finish(finish),
    .amt   (amt)
  );

  msh_step #(.MANT_W(MANT_W), .STEP(STEP), .AMT_W(AMT_W)) u_step (
    .md     (md_q),
    .amt    (amt),
    .acc_in (acc_w),
    .lor_in (lor_w),
    .acc_out(acc_nx),
    .lor_out(lor_nx)
  );

  // working registers
  always_ff @(posedge clk) begin
    if (rst) begin
      md_q  <= '0;
      acc_w <= '0;
      lor_w <= '0;
    end else if (accept) begin
      md_q  <= msh_mode_t'(mode);
      acc_w <= acc_mant_i;
      lor_w <= lor_mant_i;
    end else if (busy && !finish) begin
      acc_w <= acc_nx;
      lor_w <= lor_nx;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_mant_o <= '0;
      lor_mant_o <= '0;
      acc_exp_o  <= '0;
      lor_exp_o  <= '0;
      done       <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        acc_exp_o <= acc_exp_i;
        lor_exp_o <= lor_exp_i;
      end else if (finish) begin
        acc_mant_o <= acc_w;
        lor_mant_o <= lor_w;
        acc_exp_o  <= '0;
        lor_exp_o  <= '0;
      end
    end
  end

endmodule

// File: rtl/mant_shifter_chk.sv
module mant_shifter_chk #(
  parameter int MANT_W = 36,
  parameter int EXP_W  = 12,
  parameter int CNT_W  = 6,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        mode,
  input logic [CNT_W-1:0]  count,
  input logic [MANT_W-1:0] acc_mant_i,
  input logic [MANT_W-1:0] lor_mant_i,
  input logic [EXP_W-1:0]  acc_exp_i,
  input logic [EXP_W-1:0]  lor_exp_i,
  input logic [MANT_W-1:0] acc_mant_o,
  input logic [MANT_W-1:0] lor_mant_o,
  input logic [EXP_W-1:0]  acc_exp_o,
  input logic [EXP_W-1:0]  lor_exp_o,
  input logic              done
);

  logic              run_t, past_run;
  logic              take;
  logic [2:0]        cap_mode;
  logic [MANT_W-1:0] cap_acc, cap_lor;

  assign take = start && (!run_t || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_t    <= 1'b0;
      past_run <= 1'b0;
      cap_mode <= '0;
      cap_acc  <= '0;
      cap_lor  <= '0;
    end else begin
      past_run <= run_t;
      if (take) begin
        run_t    <= 1'b1;
        cap_mode <= mode;
        cap_acc  <= acc_mant_i;
        cap_lor  <= lor_mant_i;
      end else if (done) begin
        run_t <= 1'b0;
      end
    end
  end

  assert_exp_clear_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (acc_exp_o == '0) && (lor_exp_o == '0));

  assert_exp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (run_t && past_run && !done) |-> $stable(acc_exp_o) && $stable(lor_exp_o));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!done && past_run) |-> $stable(acc_mant_o) && $stable(lor_mant_o));

  assert_zero_cnt_R8: assert property (@(posedge clk) disable iff (rst)
    (take && count == '0) |=> ##1 done);

  assert_lor_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !cap_mode[1]) |-> lor_mant_o == cap_lor);

  assert_rot_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (done && cap_mode[1:0] == 2'b00) |-> $countones(acc_mant_o) == $countones(cap_acc));

  assert_rot_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (done && cap_mode[1:0] == 2'b10) |->
      ($countones(acc_mant_o) + $countones(lor_mant_o)) ==
      ($countones(cap_acc) + $countones(cap_lor)));

  assert_sign_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (done && cap_mode[0]) |-> acc_mant_o[MANT_W-1] == cap_acc[MANT_W-1]);

  assert_lor_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (done && cap_mode[1:0] == 2'b11) |-> lor_mant_o[MANT_W-1] == cap_lor[MANT_W-1]);

endmodule

bind mant_shifter mant_shifter_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .CNT_W(CNT_W), .STEP(STEP)
) u_chk (.*);

// File: tb/mant_shifter_bench.sv
module mant_shifter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [5:0]  count = '0;
  logic [35:0] acc_mant_i = '0, lor_mant_i = '0;
  logic [11:0] acc_exp_i = '0, lor_exp_i = '0;
  logic [35:0] acc_mant_o, lor_mant_o;
  logic [11:0] acc_exp_o, lor_exp_o;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  mant_shifter u_mant_shifter (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .count(count),
    .acc_mant_i(acc_mant_i), .lor_mant_i(lor_mant_i),
    .acc_exp_i(acc_exp_i), .lor_exp_i(lor_exp_i),
    .acc_mant_o(acc_mant_o), .lor_mant_o(lor_mant_o),
    .acc_exp_o(acc_exp_o), .lor_exp_o(lor_exp_o), .done(done)
  );

  // {mode, count, acc, lor}
  localparam logic [80:0] VEC [NVEC] = '{
    {3'd0, 6'd5,  36'h812345678, 36'h0ABCDEF01},  // R2
    {3'd4, 6'd41, 36'h000000F0F, 36'h555555555},  // R2
    {3'd2, 6'd13, 36'hF00000001, 36'h80000000F},  // R3
    {3'd6, 6'd63, 36'h123456789, 36'hFEDCBA987},  // R3
    {3'd1, 6'd7,  36'h7F0F0F0F1, 36'h111111111},  // R4
    {3'd5, 6'd9,  36'h900000000, 36'h222222222},  // R4
    {3'd5, 6'd3,  36'h400000008, 36'h333333333},  // R4
    {3'd3, 6'd22, 36'h0000000FF, 36'hC0F0F0F0F},  // R5
    {3'd7, 6'd17, 36'hA5A5A5A5A, 36'h87654321F},  // R5
    {3'd7, 6'd50, 36'h600000000, 36'hFFFFFFFFF},  // R5
    {3'd3, 6'd0,  36'h13579BDF1, 36'h2468ACE02},  // R8
    {3'd1, 6'd35, 36'hFFFFFFFFF, 36'h000000001}   // R4
  };

  task automatic chk(input bit ok, input string req, input logic [71:0] act,
                     input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference built from whole-word shifts of the requirement text
  task automatic model(input logic [2:0] m, input logic [5:0] n,
                       input logic [35:0] a, input logic [35:0] l,
                       output logic [35:0] ea, output logic [35:0] el);
    logic [71:0]  t72;
    logic [143:0] t144;
    logic signed [35:0] s36;
    logic signed [70:0] f71;
    int r;
    ea = a; el = l;
    case (m)
      3'd0, 3'd4: begin
        r = n % 36;
        if (m == 3'd0) begin t72 = {a, a} << r; ea = t72[71:36]; end
        else begin t72 = {a, a} >> r; ea = t72[35:0]; end
      end
      3'd2, 3'd6: begin
        r = n % 72;
        if (m == 3'd2) begin t144 = {a, l, a, l} << r; {ea, el} = t144[143:72]; end
        else begin t144 = {a, l, a, l} >> r; {ea, el} = t144[71:0]; end
      end
      3'd1, 3'd5: begin
        s36 = a;
        if (m == 3'd5) s36 = s36 >>> n;
        else s36 = s36 << n;
        ea = {a[35], s36[34:0]};
      end
      default: begin
        f71 = {a[35], a[34:0], l[34:0]};
        if (m == 3'd7) f71 = f71 >>> n;
        else f71 = f71 << n;
        ea = {a[35], f71[69:35]};
        el = {l[35], f71[34:0]};
      end
    endcase
  endtask

  logic [35:0] r_acc, r_lor;
  int          r_lat;

  task automatic run_op(input logic [2:0] m, input logic [5:0] n,
                        input logic [35:0] a, input logic [35:0] l);
    @(negedge clk);
    start = 1'b1; mode = m; count = n; acc_mant_i = a; lor_mant_i = l;
    acc_exp_i = 12'hA00 + 12'(n); lor_exp_i = 12'h5C0 + 12'(m);
    @(negedge clk);
    start = 1'b0;
    r_lat = 0;
    chk(acc_exp_o == acc_exp_i && lor_exp_o == lor_exp_i, "R7 busy exp",
        {48'd0, acc_exp_o, lor_exp_o}, {48'd0, acc_exp_i, lor_exp_i});
    while (!done && r_lat < 100) begin
      @(negedge clk);
      r_lat++;
    end
    chk(r_lat < 100, "R8 watchdog", 72'(r_lat), 72'd100);
    r_acc = acc_mant_o; r_lor = lor_mant_o;
    chk(acc_exp_o == 0 && lor_exp_o == 0, "R7 exp clear",
        {48'd0, acc_exp_o, lor_exp_o}, 72'd0);
  endtask

  initial begin
    logic [35:0] ea, el;
    repeat (3) @(negedge clk);
    chk(done == 0 && acc_mant_o == 0 && lor_mant_o == 0 && acc_exp_o == 0 &&
        lor_exp_o == 0, "R11 reset", {acc_mant_o, lor_mant_o}, 72'd0);
    rst = 1'b0;

    // R1: vector table covers all eight mode codes
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] vm; logic [5:0] vn; logic [35:0] va, vl;
      {vm, vn, va, vl} = VEC[i];
      run_op(vm, vn, va, vl);
      model(vm, vn, va, vl, ea, el);
      chk({r_acc, r_lor} == {ea, el}, "R1 vector", {r_acc, r_lor}, {ea, el});
      chk(r_lat == 1 + (int'(vn) + 3) / 4, "R8 latency", 72'(r_lat),
          72'(1 + (int'(vn) + 3) / 4));
    end

    // hand-worked corners
    run_op(3'd5, 6'd63, 36'h800000000, 36'h0);
    chk(r_acc == 36'hFFFFFFFFF, "R4 right sign fill", 72'(r_acc), 72'hFFFFFFFFF);
    run_op(3'd1, 6'd63, 36'h7FFFFFFFF, 36'h123);
    chk(r_acc == 36'h0 && r_lor == 36'h123, "R4 left discard / R6",
        {r_acc, r_lor}, {36'h0, 36'h123});
    run_op(3'd3, 6'd35, 36'h0, 36'h000000001);
    chk(r_acc == 36'h1 && r_lor == 36'h0, "R5 left cross", {r_acc, r_lor},
        {36'h1, 36'h0});
    run_op(3'd7, 6'd36, 36'h800000000, 36'h0);
    chk(r_acc == 36'hFFFFFFFFF && r_lor == 36'h400000000, "R5 right cross",
        {r_acc, r_lor}, {36'hFFFFFFFFF, 36'h400000000});
    run_op(3'd6, 6'd36, 36'h111111111, 36'h222222222);
    chk(r_acc == 36'h222222222 && r_lor == 36'h111111111, "R3 swap",
        {r_acc, r_lor}, {36'h222222222, 36'h111111111});
    run_op(3'd0, 6'd36, 36'h9ABCDEF01, 36'h0);
    chk(r_acc == 36'h9ABCDEF01, "R2 full turn", 72'(r_acc), 72'h9ABCDEF01);
    run_op(3'd4, 6'd63, 36'h000000001, 36'h777);
    chk(r_acc == 36'h000000200 && r_lor == 36'h777, "R2 right 63 / R6",
        {r_acc, r_lor}, {36'h200, 36'h777});
    run_op(3'd2, 6'd0, 36'hCAFE00001, 36'h0BEEF0002);
    chk(r_acc == 36'hCAFE00001 && r_lor == 36'h0BEEF0002 && r_lat == 1,
        "R8 zero count", {r_acc, r_lor}, {36'hCAFE00001, 36'h0BEEF0002});

    // R9: done is one cycle, outputs hold afterwards
    @(negedge clk);
    chk(done == 0, "R9 pulse", 72'(done), 72'd0);
    repeat (4) @(negedge clk);
    chk(acc_mant_o == r_acc && lor_mant_o == r_lor, "R9 hold",
        {acc_mant_o, lor_mant_o}, {r_acc, r_lor});

    // R10: second start while busy is ignored
    @(negedge clk);
    start = 1'b1; mode = 3'd0; count = 6'd61; acc_mant_i = 36'h00000ABCD;
    lor_mant_i = 36'h0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = 3'd7; count = 6'd1; acc_mant_i = 36'hFFFFFFFFF;
    lor_mant_i = 36'hFFFFFFFFF;
    @(negedge clk);
    start = 1'b0;
    r_lat = 0;
    while (!done && r_lat < 100) begin
      @(negedge clk);
      r_lat++;
    end
    model(3'd0, 6'd61, 36'h00000ABCD, 36'h0, ea, el);
    chk(acc_mant_o == ea && lor_mant_o == el, "R10 ignore busy start",
        {acc_mant_o, lor_mant_o}, {ea, el});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule